// File: doc/BRIEF.md
# Ultraviolet-Erasable Byte Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide read-mostly memory of the kind that is written once with a programming voltage and wiped with ultraviolet light. A host drives three active-low strobes: chip select, output gate and program strobe. It also drives a flag that says the programming supply is up and a flag that says the address line at position nine carries the high identification voltage. From these the block decodes one operating mode per cycle. It then returns a stored byte, a fixed identification byte, or nothing on its 8-bit output. The output comes as a data word plus a drive-enable bit, because the block has no real three-state pad.

Programming follows the physics of the cell: a write can only pull bits from 1 to 0, so the new content of a location is the old content ANDed with the input byte. A write fires once for each falling edge of the program strobe. An erase request rewrites every location to all ones, one location per clock, and a busy flag covers the whole sweep. The depth is 2**ADDR_W bytes: 14 address bits give the full 16384-byte part, and the default of 11 keeps elaboration small.

Top module: `eprom_model`

## Requirements
- R1: The array holds 2**ADDR_W bytes of DATA_W bits. Every address, from 0 up to the top address, stores its own byte independently of all other locations.
- R2: With sel_n=0, gate_n=0, strobe_n=1, id_hv=0 and vpp_ok=0 (read), the cycle after the rising edge that samples these inputs shows drv_en=1 and dout equal to the stored byte at addr.
- R3: With sel_n=1, the next cycle shows drv_en=0 and dout=00h, whatever gate_n and strobe_n are, and no location changes, even with vpp_ok=1 and a strobe pulse.
- R4: With sel_n=0 and gate_n=1, the next cycle shows drv_en=0 and dout=00h.
- R5: A rising edge that samples sel_n=0, gate_n=1, vpp_ok=1 and strobe_n=0, after a cycle with strobe_n=1, replaces the byte at addr with (old AND din). Bits never go from 0 to 1.
- R6: The same strobe pulse with vpp_ok=0 changes no location.
- R7: Holding strobe_n low for more cycles does not repeat the write, even if din changes in the meantime.
- R8: With sel_n=0, gate_n=0, strobe_n=1 and vpp_ok=1 (verify), the next cycle drives the stored byte at addr.
- R9: With sel_n=0, gate_n=0, strobe_n=1 and id_hv=1, the next cycle drives the maker code 20h when addr[0]=0 and the part code 89h when addr[0]=1. This mode takes precedence over read and verify.
- R10: An erase_req sampled while idle raises busy at that edge. Busy stays high for exactly 2**ADDR_W cycles, and afterwards every location reads FFh.
- R11: While busy is high, drv_en stays 0, program pulses are ignored and a further erase_req does not lengthen the sweep.
- R12: During reset and on the first cycle after it, busy=0, drv_en=0 and dout=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| gate_n | input | 1 | Output gate, active low |
| strobe_n | input | 1 | Program strobe, active low |
| vpp_ok | input | 1 | Programming supply present |
| id_hv | input | 1 | High voltage on address line nine |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| erase_req | input | 1 | Request a full-array erase |
| dout | output | DATA_W | Output byte, 00h when not driven |
| drv_en | output | 1 | Output drive enable |
| busy | output | 1 | Erase sweep in progress |

## Verification
The assertions assume that every control input is synchronous to clk and is stable at each rising edge. They also assume that erase is the only way to bring the array to a known state, so no property talks about stored contents before the first erase has finished. The stimulus changes inputs only on falling edges, erases the array before it reads anything, and always precedes a program pulse with a cycle of strobe_n=1 so that each intended write has a clean falling edge. One sweep is deliberately disturbed with a program pulse and a repeated erase request while busy is high.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_QUIET   = 3'd1,
    OP_READ    = 3'd2,
    OP_VERIFY  = 3'd3,
    OP_PROG    = 3'd4,
    OP_IDENT   = 3'd5
  } op_mode_e;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h89;

  function automatic logic op_drives(input op_mode_e m);
    return (m == OP_READ) || (m == OP_VERIFY) || (m == OP_IDENT);
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic     sel_n,
  input  logic     gate_n,
  input  logic     strobe_n,
  input  logic     vpp_ok,
  input  logic     id_hv,
  output op_mode_e mode
);

  always_comb begin
    mode = OP_QUIET;
    if (sel_n) begin
      mode = OP_STANDBY;
    end else if (!gate_n && strobe_n) begin
      if (id_hv)       mode = OP_IDENT;
      else if (vpp_ok) mode = OP_VERIFY;
      else             mode = OP_READ;
    end else if (gate_n && !strobe_n && vpp_ok) begin
      mode = OP_PROG;
    end
  end

endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (busy_q) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_q + 1'b1;
      if (ptr_q == LAST) busy_d = 1'b0;
    end else if (start) begin
      ptr_en = 1'b1;
      ptr_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q;
  assign wr_addr = ptr_q;

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              gate_n,
  input  logic              strobe_n,
  input  logic              vpp_ok,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              erase_req,
  output logic [DATA_W-1:0] dout,
  output logic              drv_en,
  output logic              busy
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CODE_LO  = DATA_W'(ID_MAKER);
  localparam logic [DATA_W-1:0] CODE_HI  = DATA_W'(ID_PART);

  op_mode_e          mode;
  logic              strobe_q;
  logic              prog_wr;
  logic              ers_we;
  logic [ADDR_W-1:0] ers_addr;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata;
  logic [DATA_W-1:0] cell_rd;
  logic [DATA_W-1:0] dout_d, dout_q;
  logic              en_d, en_q;

  eprom_mode_dec u_dec (
    .sel_n    (sel_n),
    .gate_n   (gate_n),
    .strobe_n (strobe_n),
    .vpp_ok   (vpp_ok),
    .id_hv    (id_hv),
    .mode     (mode)
  );

  eprom_erase_seq #(.ADDR_W(ADDR_W)) u_ers (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (erase_req),
    .busy    (busy),
    .wr_en   (ers_we),
    .wr_addr (ers_addr)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (addr),
    .rdata (cell_rd)
  );

  // one write per falling strobe edge
  assign prog_wr = (mode == OP_PROG) && strobe_q && !busy;

  always_comb begin
    if (ers_we) begin
      arr_we    = 1'b1;
      arr_waddr = ers_addr;
      arr_wdata = ALL_ONES;
    end else begin
      arr_we    = prog_wr;
      arr_waddr = addr;
      arr_wdata = cell_rd & din;
    end
  end

  always_comb begin
    en_d   = op_drives(mode) && !busy;
    dout_d = '0;
    if (en_d) begin
      if (mode == OP_IDENT) dout_d = addr[0] ? CODE_HI : CODE_LO;
      else                  dout_d = cell_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      en_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      strobe_q <= strobe_n;
      en_q     <= en_d;
      dout_q   <= dout_d;
    end
  end

  assign dout   = dout_q;
  assign drv_en = en_q;

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              gate_n,
  input logic              strobe_n,
  input logic              id_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              drv_en,
  input logic              busy,
  input logic              prog_wr
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] sweep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sweep_cnt <= '0;
    else if (busy) sweep_cnt <= sweep_cnt + 1'b1;
    else           sweep_cnt <= '0;
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n) |-> (!drv_en && dout == '0)); // R3

  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel_n && gate_n) |-> !drv_en); // R4

  AST_IDENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel_n && !gate_n && strobe_n && id_hv && !busy) |->
      (drv_en && dout == ($past(addr[0]) ? DATA_W'(8'h89) : DATA_W'(8'h20)))); // R9

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr |=> !prog_wr); // R7

  AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sweep_cnt == (ADDR_W+1)'(DEPTH))); // R10

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !drv_en); // R11

  AST_BUSY_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_wr); // R11

endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .gate_n   (gate_n),
  .strobe_n (strobe_n),
  .id_hv    (id_hv),
  .addr     (addr),
  .dout     (dout),
  .drv_en   (drv_en),
  .busy     (busy),
  .prog_wr  (prog_wr)
);

// File: tb/eprom_model_bench.sv
module eprom_model_bench;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          s;
    logic          g;
    logic          p;
    logic          v;
    logic          h;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ee;
    logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h005,8'h00,1'b1,8'hFF}, // R2 erased read
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h005,8'hA5,1'b0,8'h00}, // R4 setup
    '{1'b0,1'b1,1'b0,1'b1,1'b0,11'h005,8'hA5,1'b0,8'h00}, // R5 pulse
    '{1'b0,1'b1,1'b0,1'b1,1'b0,11'h005,8'h00,1'b0,8'h00}, // R7 held low
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h005,8'h00,1'b0,8'h00},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,11'h005,8'h00,1'b1,8'hA5}, // R8 R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h005,8'h00,1'b1,8'hA5}, // R2
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h005,8'h0F,1'b0,8'h00},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,11'h005,8'h0F,1'b0,8'h00}, // R5 second
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h005,8'h0F,1'b0,8'h00},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h005,8'h00,1'b1,8'h05}, // R5 AND
    '{1'b0,1'b1,1'b1,1'b0,1'b0,11'h006,8'h00,1'b0,8'h00},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,11'h006,8'h00,1'b0,8'h00}, // R6 no vpp
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h006,8'h00,1'b1,8'hFF}, // R6
    '{1'b1,1'b1,1'b1,1'b1,1'b0,11'h007,8'h00,1'b0,8'h00}, // R3
    '{1'b1,1'b1,1'b0,1'b1,1'b0,11'h007,8'h00,1'b0,8'h00}, // R3 inhibit
    '{1'b1,1'b0,1'b1,1'b0,1'b0,11'h007,8'h00,1'b0,8'h00}, // R3 gate low
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h007,8'h00,1'b1,8'hFF}, // R3 intact
    '{1'b0,1'b1,1'b1,1'b0,1'b0,11'h005,8'h00,1'b0,8'h00}, // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b1,11'h000,8'h00,1'b1,8'h20}, // R9
    '{1'b0,1'b0,1'b1,1'b0,1'b1,11'h001,8'h00,1'b1,8'h89}, // R9
    '{1'b0,1'b0,1'b1,1'b1,1'b1,11'h005,8'h00,1'b1,8'h89}, // R9 over verify
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h7FF,8'h3C,1'b0,8'h00},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,11'h7FF,8'h3C,1'b0,8'h00}, // R1 top
    '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h7FF,8'h3C,1'b0,8'h00},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h7FF,8'h00,1'b1,8'h3C}, // R1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h000,8'h00,1'b1,8'hFF}  // R1 bottom
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, gate_n, strobe_n, vpp_ok, id_hv, erase_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          drv_en, busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  eprom_model #(.ADDR_W(AW), .DATA_W(DW)) u_eprom_model (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n),
    .strobe_n(strobe_n), .vpp_ok(vpp_ok), .id_hv(id_hv), .addr(addr),
    .din(din), .erase_req(erase_req), .dout(dout), .drv_en(drv_en),
    .busy(busy)
  );

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got en=%b data=%h, expected en=%b data=%h",
               req, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; gate_n = 1'b1; strobe_n = 1'b1; vpp_ok = 1'b0;
    id_hv = 1'b0; addr = '0; din = '0;
  endtask

  task automatic apply(input vec_t v);
    sel_n = v.s; gate_n = v.g; strobe_n = v.p; vpp_ok = v.v;
    id_hv = v.h; addr = v.a; din = v.d;
  endtask

  task automatic step(input string req, input vec_t v);
    @(negedge clk) apply(v);
    @(negedge clk) check(req, {drv_en, dout}, {v.ee, v.ed});
  endtask

  task automatic sweep(input bit poke);
    int cnt;
    @(negedge clk) erase_req = 1'b1;
    @(negedge clk) erase_req = 1'b0;
    check("R10 busy rises", {1'b0, 7'd0, busy}, {1'b0, 7'd0, 1'b1});
    cnt = 1;
    while (busy && cnt < DEPTH + 10) begin
      @(negedge clk);
      if (busy) cnt++;
      if (poke && cnt == 20) begin
        sel_n = 1'b0; gate_n = 1'b1; vpp_ok = 1'b1; addr = 11'h009;
        din = 8'h00; strobe_n = 1'b0; erase_req = 1'b1;
      end
      if (poke && cnt == 21) begin
        strobe_n = 1'b1; erase_req = 1'b0; gate_n = 1'b0; vpp_ok = 1'b0;
      end
      if (poke && cnt == 23)
        check("R11 no drive while busy", {drv_en, dout}, {1'b0, 8'h00});
    end
    check("R10 sweep length", (DW+1)'(cnt), (DW+1)'(DEPTH));
    idle();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got run still active, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    erase_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 in reset", {drv_en, dout}, {1'b0, 8'h00});
    check("R12 busy in reset", {1'b0, 7'd0, busy}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset", {busy, dout}, '0);

    sweep(1'b0);

    for (int i = 0; i < NV; i++) step($sformatf("vec %0d", i), VECS[i]);

    sweep(1'b1);
    step("R11 blocked write", '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h009,8'h00,1'b1,8'hFF});
    step("R10 cleared", '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h005,8'h00,1'b1,8'hFF});
    step("R10 top cleared", '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h7FF,8'h00,1'b1,8'hFF});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule